// File: doc/BRIEF.md
# Programmable Port I/O Cell

This block is the I/O cell behind one port of a switch-style device. It sits between a bidirectional pad and the device core. A parallel configuration word sets its behaviour. The word comes from a configuration register outside the block. It decides whether the pad is driven, whether the input and output data paths are registered, and which clock they use.

The input path can pass pad data straight to the core (flow-through). It can instead capture the pad on an edge of the selected clock. That clock is one of two global clocks or the pad signal of the next higher-numbered port (neighbour clocking), and either clock polarity can be chosen. The output path drives core data to the pad in one of three ways: combinationally with optional inversion, through an edge-triggered register, or as a plain non-inverting repeater. An active-low asynchronous reset returns the port to input mode and clears both data registers.

Top module: `pio_cell`

## Requirements
- R1: While `rst_ni` is low, `pad_oe_o` is 0 whatever the configuration, and both data registers clear to 0.
- R2: Out of reset, `pad_oe_o` equals the output-enable bit, `cfg_i[5]`.
- R3: When the clock-select field `cfg_i[4:3]` is 00, `core_o` follows `pad_i` combinationally, and no clock input has any effect on it.
- R4: With clock select 01 (global clock A) or 10 (global clock B) and `cfg_i[1]`=0, `core_o` takes the value of `pad_i` on the rising edge of that clock only. Edges on the other two clock sources leave it unchanged.
- R5: With clock select 11, the input register captures `pad_i` on the rising edge of the neighbour port signal `nbr_i`.
- R6: With `cfg_i[1]`=1, the input register captures on the falling edge of the selected source, not on the rising edge.
- R7: With `cfg_i[6]`=0 and `cfg_i[7]`=0, `pad_o` equals `core_i`, inverted when `cfg_i[2]`=1.
- R8: With `cfg_i[6]`=1, `cfg_i[7]`=0 and a nonzero clock select, `pad_o` takes `core_i` on the selected source's rising edge. When `cfg_i[0]`=1 it takes `core_i` on the falling edge instead. `cfg_i[2]` has no effect.
- R9: With `cfg_i[7]`=1 (repeater), `pad_o` equals `core_i` combinationally, whatever `cfg_i[2]` and `cfg_i[6]` hold.
- R10: Bits `cfg_i[19:8]` are reserved, and setting them changes no output.
- R11: With `cfg_i[6]`=1 and clock select 00, `pad_o` equals `core_i` combinationally and is not inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_a_i | input | 1 | Global clock A |
| clk_b_i | input | 1 | Global clock B |
| nbr_i | input | 1 | Pad signal of the next higher-numbered port |
| cfg_i | input | CFG_W (20) | Configuration word |
| pad_i | input | 1 | Data received from the pad |
| pad_o | output | 1 | Data driven to the pad |
| pad_oe_o | output | 1 | Pad output enable |
| core_i | input | 1 | Core data to send out |
| core_o | output | 1 | Pad data delivered to the core |

## Verification
The bench builds the cell with the default 20-bit configuration word. Every data path is a single bit, so the sweep covers all four clock-select codes, both clock polarities and every output-mode combination, each with rising and falling data. Each of the three clock sources is pulsed on its own in every pass. This shows that only the selected source, on its selected edge, moves a register, including the neighbour-port source. One pass drives all reserved bits high to show they are ignored.

// File: rtl/pio_cell_pkg.sv
package pio_cell_pkg;
  localparam int CFG_W = 20;

  typedef enum logic [1:0] {
    CK_NONE = 2'b00,
    CK_GA   = 2'b01,
    CK_GB   = 2'b10,
    CK_NBR  = 2'b11
  } ck_sel_e;

  // field order is the bit layout, msb first: [7]..[0]
  typedef struct packed {
    logic    rep;
    logic    reg_out;
    logic    oe;
    ck_sel_e sel;
    logic    dinv;
    logic    iinv;
    logic    oinv;
  } cfg_t;

  localparam int CFG_USED = $bits(cfg_t);
endpackage

// File: rtl/pio_clk_sel.sv
module pio_clk_sel
  import pio_cell_pkg::*;
(
  input  ck_sel_e sel_i,
  input  logic    inv_i,
  input  logic    ga_i,
  input  logic    gb_i,
  input  logic    nbr_i,
  output logic    clk_o
);
  logic src;

  always_comb begin
    unique case (sel_i)
      CK_GA:   src = ga_i;
      CK_GB:   src = gb_i;
      CK_NBR:  src = nbr_i;
      default: src = 1'b0;
    endcase
  end

  assign clk_o = src ^ inv_i;
endmodule

// File: rtl/pio_in_path.sv
module pio_in_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic pad_i,
  output logic core_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= pad_i;
  end

  assign core_o = bypass_i ? pad_i : q;
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_en_i,
  input  logic inv_en_i,
  input  logic core_i,
  output logic pad_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= core_i;
  end

  assign pad_o = reg_en_i ? q : (core_i ^ inv_en_i);
endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_cell_pkg::*;
#(
  parameter int CFG_W = pio_cell_pkg::CFG_W
) (
  input  logic             rst_ni,
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             nbr_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe_o,
  input  logic             core_i,
  output logic             core_o
);
  localparam int RSVD_W = CFG_W - CFG_USED;

  cfg_t cfg;
  assign cfg = cfg_t'(cfg_i[CFG_USED-1:0]);

  generate
    if (RSVD_W > 0) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^cfg_i[CFG_W-1:CFG_USED];
    end
  endgenerate

  logic clk_in, clk_out;
  logic clocked, out_reg_en, out_inv_en;

  assign clocked    = (cfg.sel != CK_NONE);
  // repeater wins over register; either mode blocks inversion
  assign out_reg_en = cfg.reg_out & ~cfg.rep & clocked;
  assign out_inv_en = cfg.dinv & ~cfg.reg_out & ~cfg.rep;

  pio_clk_sel u_ck_in (
    .sel_i (cfg.sel), .inv_i (cfg.iinv),
    .ga_i  (clk_a_i), .gb_i  (clk_b_i), .nbr_i (nbr_i),
    .clk_o (clk_in)
  );

  pio_clk_sel u_ck_out (
    .sel_i (cfg.sel), .inv_i (cfg.oinv),
    .ga_i  (clk_a_i), .gb_i  (clk_b_i), .nbr_i (nbr_i),
    .clk_o (clk_out)
  );

  pio_in_path u_in (
    .clk_i    (clk_in),
    .rst_ni   (rst_ni),
    .bypass_i (~clocked),
    .pad_i    (pad_i),
    .core_o   (core_o)
  );

  pio_out_path u_out (
    .clk_i    (clk_out),
    .rst_ni   (rst_ni),
    .reg_en_i (out_reg_en),
    .inv_en_i (out_inv_en),
    .core_i   (core_i),
    .pad_o    (pad_o)
  );

  assign pad_oe_o = cfg.oe & rst_ni;
endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oe_bit_i,
  input logic       dinv_i,
  input logic [1:0] sel_i,
  input logic       rego_i,
  input logic       rep_i,
  input logic       pad_i,
  input logic       pad_o,
  input logic       pad_oe_o,
  input logic       core_i,
  input logic       core_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      oe_in_reset_chk: assert (!pad_oe_o);
    end
  end

  // R2
  oe_needs_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o |-> oe_bit_i);

  // R3
  flow_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b00) |-> (core_o == pad_i));

  // R7
  out_invert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dinv_i && !rego_i && !rep_i) |-> (pad_o != core_i));

  // R9
  repeater_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_i |-> (pad_o == core_i));

  // R11
  reg_no_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rego_i && !rep_i && sel_i == 2'b00) |-> (pad_o == core_i));
endmodule

bind pio_cell pio_cell_chk u_chk (
  .clk_i    (clk_a_i),
  .rst_ni   (rst_ni),
  .oe_bit_i (cfg_i[5]),
  .dinv_i   (cfg_i[2]),
  .sel_i    (cfg_i[4:3]),
  .rego_i   (cfg_i[6]),
  .rep_i    (cfg_i[7]),
  .pad_i    (pad_i),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .core_i   (core_i),
  .core_o   (core_o)
);

// File: tb/pio_cell_tb.sv
module pio_cell_tb;
  localparam int CW = 20;

  logic tb_clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0, nbr = 1'b0;
  logic [CW-1:0] cfg = '0;
  logic pad_i = 1'b0, core_i = 1'b0;
  logic pad_o, pad_oe_o, core_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 tb_clk = ~tb_clk;  // 125 MHz

  pio_cell u_dut (
    .rst_ni   (rst_ni),
    .clk_a_i  (clk_a),
    .clk_b_i  (clk_b),
    .nbr_i    (nbr),
    .cfg_i    (cfg),
    .pad_i    (pad_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o),
    .core_i   (core_i),
    .core_o   (core_o)
  );

  always @(posedge tb_clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [CW-1:0] mk(input logic rep, input logic rego, input logic oe,
                                       input logic [1:0] sel, input logic dinv,
                                       input logic iinv, input logic oinv);
    return {{(CW-8){1'b0}}, rep, rego, oe, sel, dinv, iinv, oinv};
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic set_clk(input int idx, input logic v);
    case (idx)
      0: clk_a = v;
      1: clk_b = v;
      default: nbr = v;
    endcase
  endtask

  task automatic restart(input logic [CW-1:0] c);
    rst_ni = 1'b0;
    #2 cfg = c;
    #4 chk(pad_oe_o, 1'b0, "R1");
    rst_ni = 1'b1;
    #4;
  endtask

  // pulse one clock source; which=0 checks core_o, 1 checks pad_o
  task automatic pulse_chk(input int idx, input int which, input logic exp_r,
                           input logic exp_f, input string tag_r, input string tag_f);
    set_clk(idx, 1'b1);
    #4 chk(which == 0 ? core_o : pad_o, exp_r, tag_r);
    set_clk(idx, 1'b0);
    #4 chk(which == 0 ? core_o : pad_o, exp_f, tag_f);
  endtask

  initial begin
    #6;
    // R1: reset with output enabled; registers clear
    restart(mk(1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0));
    chk(pad_oe_o, 1'b1, "R2");
    pad_i = 1'b1;
    pulse_chk(0, 0, 1'b1, 1'b1, "R4", "R4");
    rst_ni = 1'b0;
    #4 chk(core_o, 1'b0, "R1");
    chk(pad_oe_o, 1'b0, "R1");
    #4 rst_ni = 1'b1;
    pad_i = 1'b0;

    // R2: output enable bit
    for (int oe = 0; oe < 2; oe++) begin
      restart(mk(1'b0, 1'b0, oe[0], 2'b00, 1'b0, 1'b0, 1'b0));
      chk(pad_oe_o, oe[0], "R2");
    end

    // R3: flow-through, clocks ignored
    restart(mk(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0));
    for (int d = 0; d < 4; d++) begin
      pad_i = d[0] ^ 1'b1;
      #2 chk(core_o, pad_i, "R3");
      for (int k = 0; k < 3; k++) pulse_chk(k, 0, pad_i, pad_i, "R3", "R3");
    end

    // R4/R5/R6: registered input sweep
    for (int s = 1; s < 4; s++) begin
      for (int inv = 0; inv < 2; inv++) begin
        logic held;
        string tr, tf;
        restart(mk(1'b0, 1'b0, 1'b0, s[1:0], 1'b0, inv[0], 1'b0));
        held = 1'b0;
        tf = (s == 3) ? "R5" : "R4";
        tr = inv ? "R6" : tf;
        for (int st = 0; st < 3; st++) begin
          logic d;
          d = (st % 2 == 0);
          pad_i = d;
          for (int k = 0; k < 3; k++) begin
            logic m;
            m = (k == s - 1);
            pulse_chk(k, 0, (m && !inv) ? d : held, m ? d : held, tr, tf);
            if (m) held = d;
          end
        end
      end
    end
    pad_i = 1'b0;

    // R7: combinational output with and without inversion
    for (int inv = 0; inv < 2; inv++) begin
      restart(mk(1'b0, 1'b0, 1'b1, 2'b01, inv[0], 1'b0, 1'b0));
      for (int d = 0; d < 2; d++) begin
        core_i = d[0];
        #2 chk(pad_o, d[0] ^ inv[0], "R7");
      end
    end

    // R9: repeater ignores inversion and register bit
    for (int v = 0; v < 8; v++) begin
      restart(mk(1'b1, v[0], 1'b1, v[2] ? 2'b10 : 2'b00, v[1], 1'b0, 1'b0));
      for (int d = 0; d < 2; d++) begin
        core_i = d[0];
        #2 chk(pad_o, d[0], "R9");
        pulse_chk(1, 1, d[0], d[0], "R9", "R9");
      end
    end

    // R11: register mode with no clock selected
    for (int inv = 0; inv < 2; inv++) begin
      restart(mk(1'b0, 1'b1, 1'b1, 2'b00, inv[0], 1'b0, 1'b0));
      for (int d = 0; d < 2; d++) begin
        core_i = d[0];
        #2 chk(pad_o, d[0], "R11");
      end
    end

    // R8: registered output sweep
    for (int s = 1; s < 4; s++) begin
      for (int v = 0; v < 4; v++) begin
        logic held;
        restart(mk(1'b0, 1'b1, 1'b1, s[1:0], v[1], 1'b0, v[0]));
        held = 1'b0;
        for (int st = 0; st < 3; st++) begin
          logic d;
          d = (st % 2 == 0);
          core_i = d;
          #2 chk(pad_o, held, "R8");
          for (int k = 0; k < 3; k++) begin
            logic m;
            m = (k == s - 1);
            pulse_chk(k, 1, (m && !v[0]) ? d : held, m ? d : held, "R8", "R8");
            if (m) held = d;
          end
        end
      end
    end

    // R10: reserved bits set
    restart(mk(1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0) | {{(CW-8){1'b1}}, 8'h00});
    chk(pad_oe_o, 1'b1, "R10");
    for (int d = 0; d < 2; d++) begin
      core_i = d[0];
      pad_i = d[0];
      #2 chk(pad_o, ~d[0], "R10");
      chk(core_o, d[0], "R10");
    end
    restart({{(CW-8){1'b1}}, 8'h00});
    chk(pad_oe_o, 1'b0, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule